// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the address for a synchronous burst memory access. On a clock edge where a start strobe is active it captures an external address. After that, each edge with the advance request active steps only the burst field, which is the low-order `BURST_W` bits of the address (two bits by default, so a burst is four beats long). The bits above the burst field keep the captured value until the next load.

The burst field can step in one of two orders, chosen by a static mode input. In linear order it counts up and wraps from the captured start value. In interleaved order it is the captured start value XORed with a beat counter that counts up from zero. Two independent active-low strobes can start a burst. Strobe A acts only while the chip-select qualifier is high. Strobe B acts regardless of chip select. Loads can follow one another on every cycle with no dead cycle, so the burst function is optional.

All control and address inputs are sampled on the rising clock edge. The output is driven from registers through the order-select mux.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active, and on the first cycle after it, `addrOut` is all zeros and the beat count is zero.
- R2: An edge where `startBN` is low loads `addrIn`: from that edge `addrOut` equals the sampled `addrIn` in both orders, and the beat count returns to 0.
- R3: `startAN` low loads the address only when `chipSel` is high. With `chipSel` low, `startAN` is ignored: `addrOut` holds, or advances if `advN` is low.
- R4: With `linearN` low (linear order), every edge with `advN` low and no load sets the burst field to (loaded start + beat count) modulo 2^BURST_W, where the beat count goes up by one per advance.
- R5: With `linearN` high (interleaved order, the default), the burst field equals (loaded start field) XOR (beat count), and the beat count goes 0, 1, 2, 3 and wraps.
- R6: Between loads, the bits of `addrOut` above the burst field keep the value they were loaded with.
- R7: When a load and an advance are active on the same edge, the load wins and the beat count is 0.
- R8: With both strobes inactive (or `startAN` masked by `chipSel` low) and `advN` high, `addrOut` keeps its value.
- R9: A different address can be loaded on every one of several consecutive edges, and each one appears on `addrOut` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | External address captured on load |
| startAN | input | 1 | Start strobe A, active low, qualified by chipSel |
| startBN | input | 1 | Start strobe B, active low, unqualified |
| advN | input | 1 | Advance request, active low |
| linearN | input | 1 | Order select: low = linear, high = interleaved |
| chipSel | input | 1 | Qualifier for start strobe A, active high |
| addrOut | output | ADDR_W | Current internal address |

## Verification
The bench builds the block with ADDR_W = 10 and BURST_W = 2. This keeps the upper field small enough that random addresses often land on every start value of the burst field, while still leaving eight upper bits to catch corruption during a burst. With two burst bits, a run of four or more advances covers the wrap in both orders. Strobe collisions, masked strobe A and mode changes in the middle of a burst occur often under the random mix. Directed sequences cover back-to-back loads and load-over-advance.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic linear;
  } ctlStrobes_t;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_addr_pkg::*;
(
  input  logic        startAN,
  input  logic        startBN,
  input  logic        advN,
  input  logic        linearN,
  input  logic        chipSel,
  output ctlStrobes_t strobes
);
  logic loadReq;

  // Strobe A needs chip select; strobe B does not (R3, R2).
  assign loadReq        = ~startBN | (~startAN & chipSel);
  assign strobes.load   = loadReq;
  // Load has priority over advance (R7).
  assign strobes.step   = ~advN & ~loadReq;
  assign strobes.linear = ~linearN;
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] beatCnt;
  logic [BURST_W-1:0] burstField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (strobes.load) begin
      baseAddr <= addrIn;
      beatCnt  <= '0;
    end else if (strobes.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (strobes.linear) burstField = baseAddr[BURST_W-1:0] + beatCnt;
    else                burstField = baseAddr[BURST_W-1:0] ^ beatCnt;
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign addrOut = {baseAddr[ADDR_W-1:BURST_W], burstField};
    end else begin : g_noUpper
      assign addrOut = burstField;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              startAN,
  input  logic              startBN,
  input  logic              advN,
  input  logic              linearN,
  input  logic              chipSel,
  output logic [ADDR_W-1:0] addrOut
);
  ctlStrobes_t strobes;

  burst_ctl u_ctl (
    .startAN (startAN),
    .startBN (startBN),
    .advN    (advN),
    .linearN (linearN),
    .chipSel (chipSel),
    .strobes (strobes)
  );

  burst_dp #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addrIn  (addrIn),
    .addrOut (addrOut)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W  = 20,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              startAN,
  input logic              startBN,
  input logic              advN,
  input logic              linearN,
  input logic              chipSel,
  input logic [ADDR_W-1:0] addrOut
);
  logic loadSeen;
  assign loadSeen = !startBN || (!startAN && chipSel);

  // R2 / R3 / R7 / R9: a load shows the sampled address one edge later
  a_r2_load_visible: assert property (@(posedge clk) disable iff (!rstN)
    loadSeen |=> addrOut == $past(addrIn));

  // R6: upper field holds without a load
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !loadSeen |=> addrOut[ADDR_W-1:BURST_W] == $past(addrOut[ADDR_W-1:BURST_W]));

  // R8: idle with a steady mode keeps the address
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!loadSeen && advN) |=> (linearN != $past(linearN)) || $stable(addrOut));

  // R4: linear advance adds one to the burst field
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (!loadSeen && !advN && !linearN) |=> linearN ||
      (addrOut[BURST_W-1:0] == $past(addrOut[BURST_W-1:0]) + 1'b1));

  // R5: interleaved advance always changes the burst field
  a_r5_interleave_moves: assert property (@(posedge clk) disable iff (!rstN)
    (!loadSeen && !advN && linearN) |=> !linearN ||
      (addrOut[BURST_W-1:0] != $past(addrOut[BURST_W-1:0])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addrIn  (addrIn),
  .startAN (startAN),
  .startBN (startBN),
  .advN    (advN),
  .linearN (linearN),
  .chipSel (chipSel),
  .addrOut (addrOut)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int AW = 10;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          startAN = 1'b1;
  logic          startBN = 1'b1;
  logic          advN = 1'b1;
  logic          linearN = 1'b1;
  logic          chipSel = 1'b0;
  logic [AW-1:0] addrOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [AW-1:0] mBase = '0;
  logic [BW-1:0] mBeat = '0;
  string         tag = "R1";

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_W(BW)) u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .startAN(startAN),
    .startBN(startBN), .advN(advN), .linearN(linearN),
    .chipSel(chipSel), .addrOut(addrOut)
  );

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] b, logic [BW-1:0] k, logic linN);
    logic [BW-1:0] f;
    f = linN ? (b[BW-1:0] ^ k) : (b[BW-1:0] + k);
    return {b[AW-1:BW], f};
  endfunction

  task automatic checkNow();
    logic [AW-1:0] e;
    e = expAddr(mBase, mBeat, linearN);
    checks++;
    if (addrOut !== e) begin
      errors++;
      $display("FAIL %s addrOut=%h expected=%h", tag, addrOut, e);
    end
    checks++;
    if (addrOut[AW-1:BW] !== mBase[AW-1:BW]) begin
      errors++;
      $display("FAIL R6 upper=%h expected=%h", addrOut[AW-1:BW], mBase[AW-1:BW]);
    end
  endtask

  task automatic cyc(input logic sa, input logic sb, input logic av, input logic ln,
                     input logic cs, input logic [AW-1:0] a, input string t);
    @(negedge clk);
    checkNow();
    startAN = sa; startBN = sb; advN = av; linearN = ln; chipSel = cs; addrIn = a;
    if (!sb || (!sa && cs)) begin
      mBase = a; mBeat = '0;
      tag = !av ? "R7" : (!sb ? "R2" : "R3");
    end else if (!av) begin
      mBeat = mBeat + 1'b1;
      tag = ln ? "R5" : "R4";
    end else begin
      tag = "R8";
    end
    if (!sa && !cs && sb) tag = "R3";
    if (t != "") tag = t;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (addrOut !== '0) begin
      errors++;
      $display("FAIL R1 addrOut=%h expected=0", addrOut);
    end
    rstN = 1'b1;
    tag = "R1";
    // R4: linear wrap from start 3 (3,0,1,2,3)
    cyc(1, 0, 1, 0, 0, 10'h2A7, "");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, '0, "");
    // R5: interleaved from start 2 (2,3,0,1,2)
    cyc(0, 1, 1, 1, 1, 10'h156, "");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 1, 0, '0, "");
    // R7: load with advance
    cyc(1, 0, 0, 1, 0, 10'h3F1, "");
    // R3: masked strobe A, hold then advance
    cyc(0, 1, 1, 1, 0, 10'h000, "R3");
    cyc(0, 1, 0, 1, 0, 10'h0FF, "R3");
    // R9: back-to-back loads
    for (int i = 0; i < 6; i++) cyc(1, 0, 1, i[0], 0, AW'(10'h040 + i * 37), "R9");
    // R8: hold
    cyc(1, 1, 1, 0, 0, 10'h123, "R8");
    cyc(1, 1, 1, 0, 1, 10'h321, "R8");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic sa, sb, av, ln, cs;
      sa = ($urandom % 5) == 0;
      sb = ($urandom % 6) == 0;
      av = ($urandom % 3) != 0;
      ln = ($urandom % 16) == 0 ? ~linearN : linearN;
      cs = $urandom % 2;
      cyc(~sa, ~sb, ~av, ln, cs, AW'($urandom), "");
    end
    @(negedge clk);
    checkNow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule